// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter Node

Several processors share one external bus without a central arbiter. Every processor holds an identical copy of this node. Each node drives one request wire of its own and watches all the request wires. All nodes register those wires on the same clock edge and run the same decision logic on them, so every copy reaches the same owner in the same cycle. The local side raises `local_req`, waits for `grant`, and may raise `local_lock` to keep the bus across several back-to-back accesses.

A static mode input selects the priority scheme. In fixed mode the lowest node ID wins. In rotating mode the search starts at the ID just above the previous owner, so the previous owner falls to the lowest priority. A time-out counter is loaded with `tmo_limit` on every change of owner. When it runs out, the owner is forced off the bus. The node then holds its own request wire low for one cycle, and every node leaves it out of that cycle's decision. While the shared lock wire is high, the time-out cannot fire.

The controller has three states. ST_IDLE means no owner. ST_BUSY means an owner holds the bus. ST_YIELD is the single cycle after a time-out. The transitions are:
- IDLE→BUSY when any registered request is seen.
- BUSY→IDLE when the owner's registered request drops.
- BUSY→YIELD when the counter is at zero and the registered lock is low.
- YIELD→BUSY when another node is requesting.
- YIELD→IDLE when no other node is requesting.

Top module: `shbus_arb_node`

## Requirements
- R1: After reset, `bus_busy` and `grant` are 0 in every node.
- R2: `req_out` equals `local_req`, except during the forced-release cycle. All nodes connected to the same wires show the same `bus_busy` and `owner_id` every cycle, and at most one `grant` is high.
- R3: With `rotate_mode`=0, the requesting node with the lowest ID is chosen.
- R4: With `rotate_mode`=1, the search starts at ID (previous owner + 1) and wraps modulo N_NODES. The previous owner is the one that last left ST_BUSY.
- R5: An owner whose request stays high keeps the grant against any other request until its time-out fires.
- R6: When the owner drops its request, the bus goes through one ST_IDLE cycle before a new owner is chosen.
- R7: The counter reloads with `tmo_limit` on each acquisition. Without lock, an owner that keeps requesting holds `grant` for exactly `tmo_limit`+1 cycles.
- R8: On time-out, the expired owner drives `req_out` low for one cycle and is excluded from that cycle's choice. Another requester is granted at once.
- R9: While the registered `bus_lock` is 1, the owner is never timed out. `lock_out` = `grant` AND `local_lock`.
- R10: On an idle bus, `grant` rises two clock edges after the edge at which the node's request wire is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all nodes |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ID_W | This node's unique ID |
| rotate_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| tmo_limit | input | TMO_W | Time-out reload value |
| local_req | input | 1 | Local side requests the bus |
| local_lock | input | 1 | Local side asks to keep the bus |
| req_lines | input | N_NODES | All request wires, bit i from node i |
| bus_lock | input | 1 | Shared lock wire (OR of all lock_out) |
| req_out | output | 1 | This node's request wire |
| lock_out | output | 1 | This node's contribution to the lock wire |
| grant | output | 1 | This node owns the bus |
| bus_busy | output | 1 | Some node owns the bus |
| owner_id | output | ID_W | ID of the current or last owner |

## Verification
A wrong owner register or a wrong priority start point shows up within one cycle. Neighbouring nodes then report a different `owner_id`, or two `grant` outputs are high at once. A counter that reloads wrongly or fails to saturate changes how many cycles `grant` stays high under a continuous request. A missing exclusion during ST_YIELD hands the bus straight back to the expired owner, which the next sample of the other node's `grant` reveals.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_YIELD = 2'd2
    } arb_state_e;
endpackage

// File: rtl/shbus_pick.sv
// Round search over the request vector starting at a given index.
module shbus_pick #(
    parameter int N_NODES = 6,
    localparam int ID_W = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic [N_NODES-1:0] req,
    input  logic [ID_W-1:0]    start,
    output logic               valid,
    output logic [ID_W-1:0]    idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 0; k < N_NODES; k++) begin
            if (!valid && req[(int'(start) + k) % N_NODES]) begin
                valid = 1'b1;
                idx   = ID_W'((int'(start) + k) % N_NODES);
            end
        end
    end

    // R3/R4: a chosen index always carries a live request
    always_comb begin
        if (valid) begin
            a_r3_pick_live: assert (req[idx]);
        end
    end
endmodule

// File: rtl/shbus_tmo.sv
// Ownership time-out counter: reload on acquisition, count down, saturate.
module shbus_tmo #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= limit;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(limit)));
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/shbus_arb_node.sv
module shbus_arb_node
    import shbus_pkg::*;
#(
    parameter int N_NODES = 6,
    parameter int TMO_W   = 8,
    localparam int ID_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    node_id,
    input  logic               rotate_mode,
    input  logic [TMO_W-1:0]   tmo_limit,
    input  logic               local_req,
    input  logic               local_lock,
    input  logic [N_NODES-1:0] req_lines,
    input  logic               bus_lock,
    output logic               req_out,
    output logic               lock_out,
    output logic               grant,
    output logic               bus_busy,
    output logic [ID_W-1:0]    owner_id
);
    arb_state_e         state, nxt;
    logic [N_NODES-1:0] req_q;
    logic               lock_q;
    logic [ID_W-1:0]    owner, last;
    logic [ID_W-1:0]    start;
    logic [N_NODES-1:0] excl, cand;
    logic               pick_valid;
    logic [ID_W-1:0]    pick_idx;
    logic               acquire, tmo_expired;

    // Shared view of the wires, captured on the common edge in every node
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            req_q  <= req_lines;
            lock_q <= bus_lock;
        end
    end

    assign start = rotate_mode ? ((last == ID_W'(N_NODES - 1)) ? '0 : last + 1'b1) : '0;
    assign excl  = (state == ST_YIELD) ? (N_NODES'(1) << owner) : '0;
    assign cand  = req_q & ~excl;

    shbus_pick #(.N_NODES(N_NODES)) u_pick (
        .req   (cand),
        .start (start),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    shbus_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (acquire),
        .limit   (tmo_limit),
        .expired (tmo_expired)
    );

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (pick_valid) nxt = ST_BUSY;
            ST_BUSY: begin
                if (!req_q[owner])                nxt = ST_IDLE;
                else if (tmo_expired && !lock_q)  nxt = ST_YIELD;
            end
            ST_YIELD: nxt = pick_valid ? ST_BUSY : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign acquire = (nxt == ST_BUSY) && (state != ST_BUSY);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
            last  <= ID_W'(N_NODES - 1);
        end else begin
            state <= nxt;
            if (acquire)                           owner <= pick_idx;
            if (state == ST_BUSY && nxt != ST_BUSY) last  <= owner;
        end
    end

    // Outputs
    always_comb begin
        bus_busy = (state == ST_BUSY);
        grant    = bus_busy && (owner == node_id);
        req_out  = local_req && !((state == ST_YIELD) && (owner == node_id));
        lock_out = grant && local_lock;
        owner_id = owner;
    end

    a_r5_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && req_q[owner] && !tmo_expired) |=> (state == ST_BUSY && $stable(owner)));
    a_r6_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !req_q[owner]) |=> (state == ST_IDLE));
    a_r8_yield_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YIELD) |=> (state != ST_YIELD));
    a_r8_no_self_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YIELD && pick_valid) |=> (owner != $past(owner)));
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && lock_q && req_q[owner]) |=> (state == ST_BUSY));
endmodule

// File: tb/shbus_arb_node_tb.sv
module shbus_arb_node_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 4;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rotate = 1'b0;
    logic [TW-1:0] limit = 8'd200;
    logic [NN-1:0] lreq = '0;
    logic [NN-1:0] llock = '0;
    logic [NN-1:0] reqs, lock_outs, gnt, busy;
    logic [1:0]    own [NN];
    logic          lock_w;
    int            tests = 0, fails = 0, mism = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign lock_w = |lock_outs;

    for (genvar i = 0; i < NN; i++) begin : g_node
        shbus_arb_node #(.N_NODES(NN), .TMO_W(TW)) dut_i (
            .clk(clk), .rst_n(rst_n), .node_id(2'(i)), .rotate_mode(rotate),
            .tmo_limit(limit), .local_req(lreq[i]), .local_lock(llock[i]),
            .req_lines(reqs), .bus_lock(lock_w), .req_out(reqs[i]),
            .lock_out(lock_outs[i]), .grant(gnt[i]), .bus_busy(busy[i]),
            .owner_id(own[i])
        );
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // R2 agreement monitor: every node sees the same owner state
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 1; i < NN; i++)
                if (own[i] != own[0] || busy[i] != busy[0]) mism++;
            if (!$onehot0(gnt)) mism++;
            if (busy[0] && !gnt[own[0]]) mism++;
        end
    end

    // {rotate, local requests[3:0], expected grants[3:0]}
    localparam logic [8:0] VEC [13] = '{
        {1'b0, 4'b1010, 4'b0010},
        {1'b0, 4'b1011, 4'b0010},
        {1'b0, 4'b1001, 4'b0001},
        {1'b0, 4'b1000, 4'b1000},
        {1'b0, 4'b0000, 4'b0000},
        {1'b1, 4'b1111, 4'b0001},
        {1'b1, 4'b1110, 4'b0010},
        {1'b1, 4'b1101, 4'b0100},
        {1'b1, 4'b1011, 4'b1000},
        {1'b1, 4'b0011, 4'b0001},
        {1'b1, 4'b0000, 4'b0000},
        {1'b0, 4'b1100, 4'b0100},
        {1'b0, 4'b0000, 4'b0000}
    };

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        bit saw_drop;
        string tag;
        repeat (3) @(negedge clk);
        check(gnt == '0 && busy == '0, "R1 reset grants", gnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt == '0 && busy == '0, "R1 after reset", {busy, gnt}, 0);

        for (int v = 0; v < 13; v++) begin
            rotate = VEC[v][8];
            lreq   = VEC[v][7:4];
            repeat (4) @(negedge clk);
            tag = VEC[v][8] ? "R4 rotating" : "R3 fixed";
            if (v == 1) tag = "R5 no preemption";
            if (v == 2) tag = "R6 release handover";
            check(gnt == VEC[v][3:0], tag, gnt, VEC[v][3:0]);
            check(reqs == lreq, "R2 request wires", reqs, lreq);
        end

        // R10 latency from an idle bus
        rotate = 1'b0;
        lreq = 4'b1000;
        @(negedge clk);
        check(gnt == 4'b0000, "R10 one edge", gnt, 0);
        @(negedge clk);
        check(gnt == 4'b1000, "R10 two edges", gnt, 4'b1000);
        lreq = '0;
        repeat (4) @(negedge clk);

        // R7/R8 time-out
        limit = 8'd3;
        lreq = 4'b0100;
        cnt = 0;
        saw_drop = 1'b0;
        for (int c = 0; c < 40 && !gnt[0]; c++) begin
            @(negedge clk);
            if (gnt[2]) cnt++;
            if (cnt == 1) lreq[0] = 1'b1;
            if (lreq[2] && !reqs[2]) saw_drop = 1'b1;
        end
        check(cnt == 4, "R7 hold cycles", cnt, 4);
        check(saw_drop, "R8 forced drop", saw_drop, 1);
        check(gnt == 4'b0001, "R8 handover", gnt, 4'b0001);
        lreq[0] = 1'b0;
        repeat (4) @(negedge clk);
        check(gnt == 4'b0100, "R7 reload regain", gnt, 4'b0100);
        lreq = '0;
        repeat (4) @(negedge clk);

        // R9 lock
        llock = 4'b0100;
        lreq = 4'b0100;
        repeat (4) @(negedge clk);
        check(lock_outs == 4'b0100, "R9 lock_out", lock_outs, 4'b0100);
        lreq[0] = 1'b1;
        repeat (20) @(negedge clk);
        check(gnt == 4'b0100, "R9 locked hold", gnt, 4'b0100);
        llock = '0;
        repeat (4) @(negedge clk);
        check(gnt == 4'b0001, "R9 unlock expiry", gnt, 4'b0001);
        check(lock_outs == '0, "R9 lock_out low", lock_outs, 0);
        lreq = '0;
        repeat (4) @(negedge clk);
        check(busy == '0, "R6 idle after drop", busy, 0);

        check(mism == 0, "R2 node agreement", mism, 0);
        finish_run();
    end
endmodule